// File: doc/BRIEF.md
# Stream Prefetch Buffer Set

This block holds lines fetched ahead of time for address streams that a stream detector has found. It has two pools of small FIFO lanes, one for read streams and one for write streams, with NB lanes in each. Lines in the write pool are held with exclusive ownership. When a stream is detected, the least recently used lane of the chosen pool is handed to it, and any contents that lane still holds are dropped. From then on the lane asks an anticipation engine for consecutive line addresses. It keeps asking until the number of stored plus outstanding lines reaches its limit. That limit is shallow for a stream first seen in this epoch and deep for one recognized from an earlier epoch. The engine returns the lines, and the lane pushes them into its FIFO.

Processor requests are compared against the oldest line of every lane in the requested pool. On a hit, the line is popped and returned together with the lane identity, so that the stream descriptor can be updated. A request that does not hit is forwarded onward. A barrier empties every lane. Each lane is a three-state machine: LN_FREE (not allocated), LN_AHEAD (allocated, with room to run further ahead, so it raises a prefetch request) and LN_FULL (allocated and at its limit). The transitions are:
- alloc: any state to LN_AHEAD.
- flush: any state to LN_FREE.
- room: LN_FULL to LN_AHEAD, once a hit lowers the lead below the limit.
- reach: LN_AHEAD to LN_FULL, once the lead reaches the limit.

Top module: `spb_top`

## Requirements
- R1: After reset every lane is free. No request hits, `pf_valid` is 0, and every valid request raises `miss_fwd`. The initial LRU order in each pool has lane 0 most recent and lane NB-1 least recent.
- R2: `alloc_id` always shows `cls*NB + lane`, where `lane` is the least recently used lane of the pool selected by `alloc_cls` (0 = read, 1 = write). An allocation without a barrier binds that lane to the new stream, discards its stored and outstanding lines, and makes it the most recent lane of its pool.
- R3: A lane's prefetch addresses start at the allocated start address and rise by one with each accepted issue (`pf_valid && pf_ready`). `pf_excl` is 1 exactly when `pf_id` is in the write pool (`pf_id >= NB`).
- R4: The lead of a lane is its stored lines plus its issued but unfilled lines. The lane requests a prefetch only while the lead is below 2 (`alloc_deep` = 0) or below 4 (`alloc_deep` = 1).
- R5: When several lanes request prefetch, the lowest `pf_id` is offered. The offer stays in place while `pf_ready` is 0.
- R6: A fill (`fill_valid`, `fill_id`) is stored only if the target lane is allocated and has an outstanding issue. Any other fill is ignored.
- R7: A request hits only when `req_addr` equals the oldest stored line of some lane in pool `req_cls`. The lowest such lane wins. A hit returns `rsp_id`, `rsp_data` and `rsp_excl` = `req_cls`, then pops that line. A match on a younger entry is a miss.
- R8: A hit makes its lane the most recent lane of its pool.
- R9: A barrier empties every lane and keeps the LRU order. In that cycle it blocks hits, allocations and prefetch offers. In the next cycle there is no hit and no prefetch offer.
- R10: In a cycle with `alloc_valid`, no request is served (it is forwarded) and `pf_valid` is 0. A fill aimed at the lane being allocated is ignored.
- R11: A fill and a hit on the same lane in the same cycle both take effect. The occupancy is unchanged and one outstanding line is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| barrier | input | 1 | Epoch barrier, flushes all lanes |
| alloc_valid | input | 1 | New stream allocation |
| alloc_cls | input | 1 | Pool of the new stream: 0 read, 1 write |
| alloc_addr | input | AW | First line address to prefetch |
| alloc_deep | input | 1 | 1 = recognized stream, deep lead |
| alloc_id | output | GW | Lane that an allocation takes now |
| pf_valid | output | 1 | Prefetch request offered |
| pf_excl | output | 1 | Prefetch is for exclusive ownership |
| pf_id | output | GW | Lane issuing the prefetch |
| pf_addr | output | AW | Line address to prefetch |
| pf_ready | input | 1 | Anticipation engine accepts the prefetch |
| fill_valid | input | 1 | Returned line |
| fill_id | input | GW | Lane of the returned line |
| fill_addr | input | AW | Line address of the returned line |
| fill_data | input | DW | Line data |
| req_valid | input | 1 | Processor request |
| req_cls | input | 1 | Request pool: 0 read, 1 write |
| req_addr | input | AW | Requested line address |
| rsp_hit | output | 1 | Request served from a lane (descriptor update) |
| rsp_excl | output | 1 | Served line is held exclusive |
| rsp_id | output | GW | Lane that served the request |
| rsp_data | output | DW | Served line data |
| miss_fwd | output | 1 | Request forwarded onward |

## Verification
The two functions that overlap are a hit pop and a fill push on the same lane. Alongside them, that lane may be offered a new prefetch. The directed part provokes this by returning the second line of a deep stream in the cycle that its first line is requested. The pseudo-random part provokes it many times by echoing accepted prefetches back as fills while requesting recently issued addresses. A behavioural model built from queues and an LRU list judges every cycle: it checks the hit lane and data, the forwarded flag, the offered prefetch lane and address, and the victim lane.

// File: rtl/spb_pkg.sv
package spb_pkg;
    // Per-lane control state.
    typedef enum logic [1:0] {
        LN_FREE  = 2'd0,
        LN_AHEAD = 2'd1,
        LN_FULL  = 2'd2
    } lane_st_e;
endpackage

// File: rtl/spb_pick.sv
// Lowest-index priority picker.
module spb_pick #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/spb_lru.sv
// Rank-based LRU order for one pool: rank 0 is most recent.
module spb_lru #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] rank_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (rank_q[i] == IW'(N - 1)) victim = IW'(i);
        end
    end
endmodule

// File: rtl/spb_lane.sv
// One stream lane: FIFO of prefetched lines, lead tracking, state machine.
module spb_lane
    import spb_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int DEPTH   = 4,
    parameter int SHALLOW = 2,
    parameter int DEEP    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          alloc,
    input  logic [AW-1:0] alloc_addr,
    input  logic          alloc_deep,
    input  logic          issue,
    input  logic          fill,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          pop,
    output logic          want_pf,
    output logic [AW-1:0] pf_addr,
    output logic          head_vld,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lane_st_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, pend_q, pend_d;
    logic [PW-1:0] rd_q, wr_q;
    logic          deep_q;
    logic [AW-1:0] nxt_q;
    logic [AW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic          fill_ok, pop_ok, iss_ok;
    logic [CW:0]   lead_d, lim;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fill_ok = fill && (st_q != LN_FREE) && (pend_q != '0) && !flush && !alloc;
        pop_ok  = pop && (cnt_q != '0) && !flush && !alloc;
        iss_ok  = issue && (st_q == LN_AHEAD) && !flush && !alloc;
        cnt_d   = cnt_q + CW'(fill_ok) - CW'(pop_ok);
        pend_d  = pend_q + CW'(iss_ok) - CW'(fill_ok);
        lead_d  = {1'b0, cnt_d} + {1'b0, pend_d};
        lim     = deep_q ? (CW + 1)'(DEEP) : (CW + 1)'(SHALLOW);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = LN_FREE;
        end else if (alloc) begin
            st_d = LN_AHEAD;
        end else begin
            unique case (st_q)
                LN_FREE:           st_d = LN_FREE;
                LN_AHEAD, LN_FULL: st_d = (lead_d < lim) ? LN_AHEAD : LN_FULL;
                default:           st_d = LN_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LN_FREE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        want_pf   = (st_q == LN_AHEAD);
        pf_addr   = nxt_q;
        head_vld  = (cnt_q != '0);
        head_addr = mem_a[rd_q];
        head_data = mem_d[rd_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            deep_q <= 1'b0;
            nxt_q  <= '0;
        end else if (flush) begin
            cnt_q  <= '0;
            pend_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
        end else if (alloc) begin
            cnt_q  <= '0;
            pend_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            deep_q <= alloc_deep;
            nxt_q  <= alloc_addr;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            if (fill_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            if (iss_ok)  nxt_q <= nxt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            mem_a[wr_q] <= fill_addr;
            mem_d[wr_q] <= fill_data;
        end
    end
endmodule

// File: rtl/spb_top.sv
// Stream prefetch buffer set: read pool (ids 0..NB-1), write pool (NB..2NB-1).
module spb_top #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NB      = 16,
    parameter int DEPTH   = 4,
    parameter int SHALLOW = 2,
    parameter int DEEP    = 4,
    localparam int GW     = $clog2(NB) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          barrier,
    input  logic          alloc_valid,
    input  logic          alloc_cls,
    input  logic [AW-1:0] alloc_addr,
    input  logic          alloc_deep,
    output logic [GW-1:0] alloc_id,
    output logic          pf_valid,
    output logic          pf_excl,
    output logic [GW-1:0] pf_id,
    output logic [AW-1:0] pf_addr,
    input  logic          pf_ready,
    input  logic          fill_valid,
    input  logic [GW-1:0] fill_id,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          req_valid,
    input  logic          req_cls,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_hit,
    output logic          rsp_excl,
    output logic [GW-1:0] rsp_id,
    output logic [DW-1:0] rsp_data,
    output logic          miss_fwd
);
    localparam int NL = 2 * NB;
    localparam int LW = GW - 1;

    logic [NL-1:0] ln_want, ln_hvld, ln_alloc, ln_fill, ln_pop, ln_issue;
    logic [AW-1:0] ln_pfa [NL];
    logic [AW-1:0] ln_ha  [NL];
    logic [DW-1:0] ln_hd  [NL];
    logic [LW-1:0] vic    [2];
    logic [NB-1:0] match;
    logic          alloc_go, hit_any, hit_go, pf_any;
    logic [LW-1:0] hit_lane;
    logic [GW-1:0] pf_pick;

    assign alloc_go = alloc_valid && !barrier;
    assign alloc_id = {alloc_cls, vic[alloc_cls]};

    // head match within the requested pool
    always_comb begin
        for (int l = 0; l < NB; l++) begin
            match[l] = ln_hvld[{req_cls, LW'(l)}] && (ln_ha[{req_cls, LW'(l)}] == req_addr);
        end
    end

    spb_pick #(.N(NB)) u_hit (.req(match), .any(hit_any), .idx(hit_lane));

    assign hit_go   = req_valid && hit_any && !alloc_valid && !barrier;
    assign rsp_hit  = hit_go;
    assign rsp_id   = {req_cls, hit_lane};
    assign rsp_data = ln_hd[rsp_id];
    assign rsp_excl = hit_go && req_cls;
    assign miss_fwd = req_valid && !hit_go;

    spb_pick #(.N(NL)) u_pf (.req(ln_want), .any(pf_any), .idx(pf_pick));

    assign pf_valid = pf_any && !barrier && !alloc_valid;
    assign pf_id    = pf_pick;
    assign pf_addr  = ln_pfa[pf_pick];
    assign pf_excl  = pf_pick[GW-1];

    for (genvar c = 0; c < 2; c++) begin : g_pool
        logic          touch;
        logic [LW-1:0] touch_idx;
        assign touch     = (alloc_go && (alloc_cls == 1'(c))) || (hit_go && (req_cls == 1'(c)));
        assign touch_idx = alloc_go ? vic[c] : hit_lane;
        spb_lru #(.N(NB)) u_lru (
            .clk      (clk),
            .rst_n    (rst_n),
            .touch    (touch),
            .touch_idx(touch_idx),
            .victim   (vic[c])
        );
    end

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign ln_alloc[g] = alloc_go && (alloc_id == GW'(g));
        assign ln_fill[g]  = fill_valid && (fill_id == GW'(g));
        assign ln_pop[g]   = hit_go && (rsp_id == GW'(g));
        assign ln_issue[g] = pf_valid && pf_ready && (pf_id == GW'(g));
        spb_lane #(
            .AW(AW), .DW(DW), .DEPTH(DEPTH), .SHALLOW(SHALLOW), .DEEP(DEEP)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (barrier),
            .alloc     (ln_alloc[g]),
            .alloc_addr(alloc_addr),
            .alloc_deep(alloc_deep),
            .issue     (ln_issue[g]),
            .fill      (ln_fill[g]),
            .fill_addr (fill_addr),
            .fill_data (fill_data),
            .pop       (ln_pop[g]),
            .want_pf   (ln_want[g]),
            .pf_addr   (ln_pfa[g]),
            .head_vld  (ln_hvld[g]),
            .head_addr (ln_ha[g]),
            .head_data (ln_hd[g])
        );
    end
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
    parameter int NB = 16,
    parameter int AW = 32,
    localparam int GW = $clog2(NB) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          barrier,
    input logic          alloc_valid,
    input logic [GW-1:0] alloc_id,
    input logic          pf_valid,
    input logic          pf_ready,
    input logic [GW-1:0] pf_id,
    input logic [AW-1:0] pf_addr,
    input logic          rsp_hit
);
    // R9
    flush_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        barrier |=> !rsp_hit);

    // R9
    flush_no_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        barrier |=> !pf_valid);

    // R2
    victim_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !barrier) |=> (alloc_id != $past(alloc_id)));

    // R3
    pf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) ##1 (pf_valid && (pf_id == $past(pf_id)))
        |-> (pf_addr == $past(pf_addr) + AW'(1)));
endmodule

bind spb_top spb_chk #(.NB(NB), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .barrier    (barrier),
    .alloc_valid(alloc_valid),
    .alloc_id   (alloc_id),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_id      (pf_id),
    .pf_addr    (pf_addr),
    .rsp_hit    (rsp_hit)
);

// File: tb/spb_top_tb.sv
module spb_top_tb;
    localparam int NB = 16;
    localparam int NL = 2 * NB;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int GW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic barrier, alloc_valid, alloc_cls, alloc_deep, pf_ready;
    logic fill_valid, req_valid, req_cls;
    logic [AW-1:0] alloc_addr, fill_addr, req_addr;
    logic [GW-1:0] fill_id;
    logic [DW-1:0] fill_data;
    logic [GW-1:0] alloc_id, pf_id, rsp_id;
    logic pf_valid, pf_excl, rsp_hit, rsp_excl, miss_fwd;
    logic [AW-1:0] pf_addr;
    logic [DW-1:0] rsp_data;

    always #5 clk = ~clk;

    spb_top #(.AW(AW), .DW(DW), .NB(NB)) u_dut (.*);

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model
    bit          m_vld [NL];
    bit          m_deep[NL];
    logic [31:0] m_next[NL];
    int          m_pend[NL];
    logic [31:0] m_qa  [NL][$];
    logic [31:0] m_qd  [NL][$];
    int          m_lru [2][$];
    int          rq_id [$];
    logic [31:0] rq_a  [$];
    logic [31:0] hist  [8];
    bit          hist_c[8];
    int          hist_p = 0;

    task automatic ck(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic touch(input int c, input int l);
        for (int i = 0; i < m_lru[c].size(); i++) begin
            if (m_lru[c][i] == l) begin
                m_lru[c].delete(i);
                break;
            end
        end
        m_lru[c].push_front(l);
    endtask

    function automatic logic [31:0] fdat(input logic [31:0] a, input int id);
        return (a * 32'd3) ^ 32'hA5A5_0000 ^ 32'(id);
    endfunction

    task automatic idle();
        barrier = 0; alloc_valid = 0; alloc_cls = 0; alloc_addr = '0; alloc_deep = 0;
        pf_ready = 0; fill_valid = 0; fill_id = '0; fill_addr = '0; fill_data = '0;
        req_valid = 0; req_cls = 0; req_addr = '0;
    endtask

    task automatic tick();
        int vic, ea, hl, pl;
        bit eh, ep, fok;
        #2;
        vic = m_lru[alloc_cls][m_lru[alloc_cls].size() - 1];
        ea  = int'(alloc_cls) * NB + vic;
        eh = 0; hl = 0;
        if (req_valid && !alloc_valid && !barrier) begin
            for (int l = 0; l < NB; l++) begin
                int g = int'(req_cls) * NB + l;
                if (!eh && m_vld[g] && m_qa[g].size() > 0 && m_qa[g][0] == req_addr) begin
                    eh = 1; hl = g;
                end
            end
        end
        ep = 0; pl = 0;
        if (!barrier && !alloc_valid) begin
            for (int g = 0; g < NL; g++) begin
                if (!ep && m_vld[g] && (m_pend[g] + m_qa[g].size()) < (m_deep[g] ? 4 : 2)) begin
                    ep = 1; pl = g;
                end
            end
        end
        ck(int'(alloc_id) == ea, "alloc_id", alloc_id, ea);
        ck(rsp_hit == eh, "rsp_hit", rsp_hit, eh);
        if (eh) begin
            ck(int'(rsp_id) == hl, "rsp_id", rsp_id, hl);
            ck(rsp_data == m_qd[hl][0], "rsp_data", rsp_data, m_qd[hl][0]);
            ck(rsp_excl == req_cls, "rsp_excl", rsp_excl, req_cls);
        end
        ck(miss_fwd == (req_valid && !eh), "miss_fwd", miss_fwd, req_valid && !eh);
        ck(pf_valid == ep, "pf_valid", pf_valid, ep);
        if (ep) begin
            ck(int'(pf_id) == pl, "pf_id", pf_id, pl);
            ck(pf_addr == m_next[pl], "pf_addr", pf_addr, m_next[pl]);
            ck(pf_excl == (pl >= NB), "pf_excl", pf_excl, pl >= NB);
        end
        // model update
        if (barrier) begin
            for (int g = 0; g < NL; g++) begin
                m_vld[g] = 0; m_pend[g] = 0; m_qa[g].delete(); m_qd[g].delete();
            end
        end else begin
            fok = fill_valid && m_vld[fill_id] && m_pend[fill_id] > 0 &&
                  !(alloc_valid && int'(fill_id) == ea);
            if (alloc_valid) begin
                m_vld[ea] = 1; m_deep[ea] = alloc_deep; m_next[ea] = alloc_addr;
                m_pend[ea] = 0; m_qa[ea].delete(); m_qd[ea].delete();
                touch(int'(alloc_cls), vic);
            end else if (eh) begin
                void'(m_qa[hl].pop_front());
                void'(m_qd[hl].pop_front());
                touch(int'(req_cls), hl % NB);
            end
            if (ep && pf_ready) begin
                rq_id.push_back(pl); rq_a.push_back(m_next[pl]);
                hist[hist_p] = m_next[pl]; hist_c[hist_p] = (pl >= NB);
                hist_p = (hist_p + 1) % 8;
                m_pend[pl]++; m_next[pl] = m_next[pl] + 1;
            end
            if (fok) begin
                m_qa[fill_id].push_back(fill_addr);
                m_qd[fill_id].push_back(fill_data);
                m_pend[fill_id]--;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_fill(input int id, input logic [31:0] a);
        fill_valid = 1; fill_id = GW'(id); fill_addr = a; fill_data = fdat(a, id);
    endtask

    task automatic do_req(input bit c, input logic [31:0] a);
        req_valid = 1; req_cls = c; req_addr = a;
    endtask

    task automatic do_alloc(input bit c, input logic [31:0] a, input bit d);
        alloc_valid = 1; alloc_cls = c; alloc_addr = a; alloc_deep = d;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) for (int l = 0; l < NB; l++) m_lru[c].push_back(l);
        for (int g = 0; g < NL; g++) begin m_vld[g] = 0; m_pend[g] = 0; m_deep[g] = 0; m_next[g] = '0; end
        for (int i = 0; i < 8; i++) begin hist[i] = '0; hist_c[i] = 0; end
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1"; do_req(0, 7); tick();
        idle(); alloc_cls = 1; do_req(1, 0); tick();
        // R2 allocation into LRU lane
        cur_req = "R2"; idle(); do_alloc(0, 100, 0); tick();
        // R4 shallow lead limit
        cur_req = "R4"; idle(); pf_ready = 1; repeat (4) tick();
        // R6 fills
        cur_req = "R6"; idle(); do_fill(15, 100); tick();
        idle(); do_fill(15, 101); tick();
        idle(); do_fill(15, 999); tick();
        idle(); do_fill(3, 300); tick();
        idle(); do_req(0, 300); tick();
        idle(); do_req(0, 999); tick();
        // R7 head-only hit
        cur_req = "R7"; idle(); do_req(0, 101); tick();
        idle(); do_req(0, 100); tick();
        // R3 address stepping
        cur_req = "R3"; idle(); pf_ready = 1; repeat (3) tick();
        // R5 arbitration and hold
        cur_req = "R5"; idle(); do_alloc(1, 500, 1); tick();
        idle(); do_alloc(0, 200, 1); tick();
        idle(); repeat (2) tick();
        idle(); pf_ready = 1; repeat (8) tick();
        // R11 fill and hit on the same lane in one cycle
        cur_req = "R11"; idle(); do_fill(14, 200); tick();
        idle(); do_req(0, 200); do_fill(14, 201); pf_ready = 1; tick();
        idle(); do_req(0, 201); tick();
        // R10 allocation cycle blocks request, prefetch and fill to victim
        cur_req = "R10"; idle(); do_fill(14, 202); tick();
        idle(); do_alloc(1, 700, 0); do_req(0, 202); do_fill(30, 55); pf_ready = 1; tick();
        idle(); do_req(0, 202); tick();
        // R8 hit refreshes LRU; sweep allocations over the read pool
        cur_req = "R8"; idle(); pf_ready = 1; do_fill(14, 203); tick();
        idle(); do_req(0, 203); tick();
        for (int i = 0; i < 18; i++) begin
            idle(); do_alloc(0, 32'(1000 + 16 * i), 0); tick();
        end
        // R9 barrier with everything else at once
        cur_req = "R9"; idle(); pf_ready = 1; repeat (3) tick();
        idle(); barrier = 1; do_alloc(1, 900, 1); do_req(0, 1272); do_fill(0, 1272);
        pf_ready = 1; tick();
        idle(); do_req(0, 1272); pf_ready = 1; tick();
        idle(); do_alloc(0, 4000, 0); tick();
        idle(); do_alloc(1, 5000, 1); tick();
        // R11 pseudo-random concurrency
        cur_req = "R11";
        for (int n = 0; n < 3000; n++) begin
            idle();
            barrier = ($urandom_range(0, 299) == 0);
            if ($urandom_range(0, 19) == 0)
                do_alloc(1'($urandom_range(0, 1)), 32'($urandom_range(0, 255)) << 4,
                         1'($urandom_range(0, 1)));
            pf_ready = ($urandom_range(0, 3) != 0);
            if (rq_id.size() > 0 && $urandom_range(0, 2) != 0) begin
                int id = rq_id.pop_front();
                logic [31:0] a = rq_a.pop_front();
                do_fill(id, a);
            end
            if ($urandom_range(0, 1) == 1) begin
                int k = $urandom_range(0, 7);
                do_req(hist_c[k], hist[k]);
            end
            tick();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule